// File: doc/BRIEF.md
# Flash Line Fetch Accelerator

This block sits between a processor's local bus and a wide flash array that is read one 128-bit line at a time. It keeps three one-line buffers, each with a line tag and a valid bit. Two buffers hold instruction lines: one is filled by sequential fetches and by read-ahead, the other by branch targets. The third holds data lines. A processor read that matches a valid buffer of its own class is answered in the same cycle. A read that misses starts one array read. The processor is held off until the word is ready.

While the flash is busy with a program or erase operation, the block holds the processor in wait and empties every buffer. A mode register selects between an off mode and an accelerated mode. In off mode every read goes to the array and nothing is kept. For simulation, the array is a behavioural model with a fixed, parameterised latency. It returns a known pattern, so each word can be predicted from its own address.

Top module: `flash_fetch_accel`

## Requirements
- R1: There are three buffers, each holding one 128-bit line tagged by address bits [ADDR_W-1:4]. An instruction request (req_is_data=0) is looked up in the sequential and branch buffers. A data request (req_is_data=1) is looked up only in the data buffer.
- R2: The returned word is chosen from the line by address bits [3:2]. The array model returns 0x5A000000 OR (address >> 2) for every word, so rsp_data equals that value for the requested address.
- R3: In accelerated mode, with the flash idle, a request that matches a valid buffer of its class raises rsp_ready in the same cycle it is presented. rsp_ready is never high without req_valid.
- R4: When the block is idle, a request that misses starts one array read. rsp_ready rises exactly READ_LAT cycles after the first cycle the request is presented, and the line is written into the chosen buffer.
- R5: While flash_busy is high, rsp_ready stays low and no array read is started. After flash_busy falls, a pending request is served.
- R6: flash_busy clears every valid bit. The first read after the operation ends starts a new array read.
- R7: When mode is off (mode value 0), every request takes the full READ_LAT. No line is kept and no read-ahead is started.
- R8: Reset selects off mode. A mode_wr pulse loads mode_in (0 off, 1 accelerated) and clears every valid bit.
- R9: An instruction hit in the sequential buffer at word offset 3 starts a background read of the next line into that buffer. A request for that next line, presented in the following cycle, is answered READ_LAT-1 cycles later.
- R10: An instruction miss whose line is the last served instruction line plus one fills the sequential buffer. Any other instruction miss fills the branch buffer and replaces the line held there.
- R11: A data miss fills only the data buffer. Instruction lines already buffered still hit after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle mode write strobe |
| mode_in | input | 1 | Mode value written: 0 off, 1 accelerated |
| req_valid | input | 1 | Processor read request, held until rsp_ready |
| req_is_data | input | 1 | 1 for a data read, 0 for an instruction fetch |
| req_addr | input | ADDR_W | Byte address of the word requested |
| flash_busy | input | 1 | Flash is programming or erasing |
| rsp_ready | output | 1 | Word is on rsp_data this cycle |
| rsp_data | output | 32 | Requested word |

## Verification
The bench builds the block with ADDR_W=12 and READ_LAT=3. With these values every line address is a short hexadecimal number, so the distinction between sequential and branch lines can be set up by hand. A latency of three also keeps a full miss, a read-ahead answer and a hit apart by cycle count: three, two and zero cycles. The cycle count measured from the ports is therefore enough to tell which path served each request.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int NBUF       = 3;

  // buffer slots: 0 sequential, 1 branch, 2 data; target code = slot + 1
  typedef enum logic [1:0] {TGT_NONE, TGT_SEQ, TGT_BRN, TGT_DAT} tgt_e;
  typedef enum logic {ST_IDLE, ST_FETCH} st_e;

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] ln,
                                                  input logic [1:0] off);
    logic [WORD_W-1:0] w;
    case (off)
      2'd0:    w = ln[0*WORD_W +: WORD_W];
      2'd1:    w = ln[1*WORD_W +: WORD_W];
      2'd2:    w = ln[2*WORD_W +: WORD_W];
      default: w = ln[3*WORD_W +: WORD_W];
    endcase
    return w;
  endfunction
endpackage

// File: rtl/flash_line_model.sv
module flash_line_model
  import ffa_pkg::*;
#(
  parameter int          TAG_W     = 15,
  parameter int          READ_LAT  = 4,
  parameter logic [31:0] WORD_BASE = 32'h5A00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_done,
  output logic [LINE_W-1:0] rd_line,
  output logic              busy_o
);
  localparam int CW = $clog2(READ_LAT + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rd_req)            cnt_d = CW'(READ_LAT);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (rd_req) tag_q <= rd_tag;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign rd_done = (cnt_q == CW'(1));

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign rd_line[w*WORD_W +: WORD_W] = WORD_BASE | 32'({tag_q, 2'(w)});
  end

  AST_ONE_READ_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !busy_o); // R4
endmodule

// File: rtl/line_buffer.sv
module line_buffer
  import ffa_pkg::*;
#(
  parameter int TAG_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              inval,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [1:0]        look_off,
  output logic              hit,
  output logic [WORD_W-1:0] word,
  output logic              valid_o
);
  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    valid_d = valid_q;
    if (clr_all || inval) valid_d = 1'b0;
    else if (fill_en)     valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (fill_en) tag_q <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) line_q <= fill_line;
  end

  assign hit     = valid_q && (tag_q == look_tag);
  assign word    = pick_word(line_q, look_off);
  assign valid_o = valid_q;

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !clr_all && !inval) |=> valid_q); // R4
endmodule

// File: rtl/flash_fetch_accel.sv
module flash_fetch_accel
  import ffa_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int READ_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_in,
  input  logic              req_valid,
  input  logic              req_is_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              flash_busy,
  output logic              rsp_ready,
  output logic [31:0]       rsp_data
);
  localparam int TAG_W = ADDR_W - 4;

  logic [TAG_W-1:0] req_tag;
  logic [1:0]       req_off;
  assign req_tag = req_addr[ADDR_W-1:4];
  assign req_off = req_addr[3:2];

  // registers
  logic             mode_q, mode_d;
  st_e              state_q, state_d;
  logic [TAG_W-1:0] ftag_q, ftag_d;
  tgt_e             ftgt_q, ftgt_d;
  logic             fdata_q, fdata_d;
  logic             spoil_q, spoil_d;
  logic [TAG_W-1:0] last_q, last_d;

  // array model
  logic              rd_req, rd_done, arr_busy;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;

  flash_line_model #(.TAG_W(TAG_W), .READ_LAT(READ_LAT)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tag(rd_tag),
    .rd_done(rd_done), .rd_line(rd_line), .busy_o(arr_busy)
  );

  // buffers
  logic [NBUF-1:0]   buf_hit, buf_valid, fill_en, inval;
  logic [WORD_W-1:0] buf_word [NBUF];
  logic              clr_all, fill_go;

  assign clr_all = flash_busy || mode_wr;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign fill_en[b] = fill_go && (ftgt_q == tgt_e'(2'(b + 1)));
    line_buffer #(.TAG_W(TAG_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .inval(inval[b]),
      .fill_en(fill_en[b]), .fill_tag(ftag_q), .fill_line(rd_line),
      .look_tag(req_tag), .look_off(req_off),
      .hit(buf_hit[b]), .word(buf_word[b]), .valid_o(buf_valid[b])
    );
  end

  // lookup
  logic look_ok, hit_seq, hit_brn, hit_dat, any_hit;
  assign look_ok = mode_q && !flash_busy && req_valid;
  assign hit_seq = look_ok && !req_is_data && buf_hit[0];
  assign hit_brn = look_ok && !req_is_data && buf_hit[1];
  assign hit_dat = look_ok &&  req_is_data && buf_hit[2];
  assign any_hit = hit_seq || hit_brn || hit_dat;

  // completion of an array read
  logic done_ok, serve_fill;
  assign done_ok    = (state_q == ST_FETCH) && rd_done && !spoil_q && !flash_busy && !mode_wr;
  assign fill_go    = done_ok && (ftgt_q != TGT_NONE);
  assign serve_fill = done_ok && req_valid && (req_is_data == fdata_q) && (req_tag == ftag_q);

  // issue decision
  logic can_issue, demand, ahead, seq_miss, issue;
  assign can_issue = (state_q == ST_IDLE) && !flash_busy && !mode_wr;
  assign demand    = can_issue && req_valid && !any_hit;
  assign ahead     = can_issue && hit_seq && (req_off == 2'd3);
  assign issue     = demand || ahead;
  assign seq_miss  = (req_tag == TAG_W'(last_q + 1'b1));

  assign rd_req = issue;
  assign rd_tag = demand ? req_tag : TAG_W'(req_tag + 1'b1);
  assign inval  = {1'b0, 1'b0, ahead};

  tgt_e issue_tgt;
  always_comb begin
    if (!mode_q)          issue_tgt = TGT_NONE;
    else if (ahead)       issue_tgt = TGT_SEQ;
    else if (req_is_data) issue_tgt = TGT_DAT;
    else if (seq_miss)    issue_tgt = TGT_SEQ;
    else                  issue_tgt = TGT_BRN;
  end

  // next state
  always_comb begin
    mode_d  = mode_wr ? mode_in : mode_q;
    state_d = state_q;
    ftag_d  = ftag_q;
    ftgt_d  = ftgt_q;
    fdata_d = fdata_q;
    spoil_d = spoil_q;
    last_d  = last_q;
    case (state_q)
      ST_IDLE: if (issue) begin
        state_d = ST_FETCH;
        ftag_d  = rd_tag;
        ftgt_d  = issue_tgt;
        fdata_d = demand && req_is_data;
        spoil_d = 1'b0;
      end
      default: begin
        spoil_d = spoil_q || flash_busy || mode_wr;
        if (rd_done) state_d = ST_IDLE;
      end
    endcase
    if (rsp_ready && !req_is_data) last_d = req_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      state_q <= ST_IDLE;
      ftag_q  <= '0;
      ftgt_q  <= TGT_NONE;
      fdata_q <= 1'b0;
      spoil_q <= 1'b0;
      last_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      state_q <= state_d;
      ftag_q  <= ftag_d;
      ftgt_q  <= ftgt_d;
      fdata_q <= fdata_d;
      spoil_q <= spoil_d;
      last_q  <= last_d;
    end
  end

  // response
  assign rsp_ready = any_hit || serve_fill;
  always_comb begin
    if (serve_fill)   rsp_data = pick_word(rd_line, req_off);
    else if (hit_seq) rsp_data = buf_word[0];
    else if (hit_brn) rsp_data = buf_word[1];
    else              rsp_data = buf_word[2];
  end

  AST_STALL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |-> !rsp_ready); // R5
  AST_BUSY_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |=> (buf_valid == '0)); // R6
  AST_OFF_HOLDS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (buf_valid == '0)); // R7
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> req_valid); // R3
  AST_MODE_WR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (buf_valid == '0)); // R8
endmodule

// File: tb/flash_fetch_accel_bench.sv
module flash_fetch_accel_bench;
  localparam int ADDR_W = 12;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_wr = 1'b0, mode_in = 1'b0;
  logic              req_valid = 1'b0, req_is_data = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              flash_busy = 1'b0;
  logic              rsp_ready;
  logic [31:0]       rsp_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_fetch_accel #(.ADDR_W(ADDR_W), .READ_LAT(LAT)) u_flash_fetch_accel (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .req_valid(req_valid), .req_is_data(req_is_data), .req_addr(req_addr),
    .flash_busy(flash_busy), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a);
    return 32'h5A00_0000 | 32'(a >> 2);
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one read; starts right after a falling edge, ends at the falling edge after service
  task automatic rd(input logic [ADDR_W-1:0] a, input logic dat, input int exp_cyc, input string rq);
    int cyc = 0;
    req_valid = 1'b1; req_addr = a; req_is_data = dat;
    #1;
    while (!rsp_ready && cyc < 50) begin
      @(negedge clk); #1; cyc++;
    end
    check(rsp_ready && cyc == exp_cyc, {rq, " cycles"}, cyc, exp_cyc);
    check(rsp_data == exp_word(a), {rq, " data"}, rsp_data, exp_word(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    mode_wr = 1'b1; mode_in = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check(rsp_ready == 1'b0, "R8 reset idle", rsp_ready, 0);
  endtask

  task automatic t_off;                 // R7 R8: reset leaves mode off
    rd(12'h100, 1'b0, LAT, "R8 first read off");
    rd(12'h100, 1'b0, LAT, "R7 repeat off");
    rd(12'h21C, 1'b0, LAT, "R7 offset3 off");
    rd(12'h220, 1'b0, LAT, "R7 no readahead");
  endtask

  task automatic t_miss_hit;
    set_mode(1'b1);
    rd(12'h200, 1'b0, LAT, "R4 miss");
    rd(12'h204, 1'b0, 0,   "R3 hit");
    rd(12'h208, 1'b0, 0,   "R2 word2");
  endtask

  task automatic t_readahead;
    rd(12'h210, 1'b0, LAT,   "R10 seq miss");
    rd(12'h21C, 1'b0, 0,     "R9 trigger hit");
    rd(12'h220, 1'b0, LAT-1, "R9 readahead");
    rd(12'h224, 1'b0, 0,     "R9 after fill");
  endtask

  task automatic t_branch;
    rd(12'h800, 1'b0, LAT, "R10 branch miss");
    rd(12'h200, 1'b0, LAT, "R10 branch replaced");
    rd(12'h210, 1'b0, LAT, "R10 seq fill");
    rd(12'h204, 1'b0, 0,   "R10 branch kept");
  endtask

  task automatic t_data;
    rd(12'h204, 1'b1, LAT, "R11 data separate");
    rd(12'h208, 1'b0, 0,   "R11 insn kept");
    rd(12'h20C, 1'b1, 0,   "R1 data hit");
  endtask

  task automatic t_busy;
    int cyc = 0;
    flash_busy = 1'b1;
    req_valid = 1'b1; req_addr = 12'h204; req_is_data = 1'b0;
    for (int i = 0; i < 5; i++) begin
      #1;
      check(rsp_ready == 1'b0, "R5 stall", rsp_ready, 0);
      @(negedge clk);
    end
    flash_busy = 1'b0;
    #1;
    while (!rsp_ready && cyc < 50) begin
      @(negedge clk); #1; cyc++;
    end
    check(rsp_ready && cyc == LAT, "R6 refetch cycles", cyc, LAT);
    check(rsp_data == exp_word(12'h204), "R5 data", rsp_data, exp_word(12'h204));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_mode;
    rd(12'h208, 1'b0, 0, "R3 hit before write");
    set_mode(1'b1);
    rd(12'h208, 1'b0, LAT, "R8 flush on write");
    set_mode(1'b0);
    rd(12'h208, 1'b0, LAT, "R7 off again");
    rd(12'h208, 1'b0, LAT, "R7 off repeat");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_miss_hit();
    t_readahead();
    t_branch();
    t_data();
    t_busy();
    t_mode();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule